// File: doc/BRIEF.md
# Edge-Interrupting General-Purpose I/O Port

This block is a 32-pin general-purpose I/O controller attached to a simple single-cycle register bus. Software sets each pin as input or output, can turn an output into an open-drain driver, and writes the level that output pins drive. Reading the data register returns a mix: the stored level for output pins and the synchronised pad level for input pins.

Every pad input passes through a two-flop synchroniser. The block then compares the last two synchronised samples to find edges. Each pin can be set to catch only falling edges or to catch both edges. A detected edge sets a sticky event bit, and software clears that bit by writing a 1 to it. A mask register chooses which event bits can reach the single interrupt output. Register bits are numbered from the most significant end: pin n of the pad vectors appears at bit 31-n of every register.

Top module: `gpio_edge_port`

## Requirements
- R1: Pad vector index n (pad_in[n], pad_out[n], pad_oe[n]) corresponds to bit 31-n of every register.
- R2: Register offsets are direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10 and edge-select 0x14. The direction, open-drain, mask and edge-select registers read back the value last written. Any other address reads 0, and a write to it changes nothing.
- R3: A direction bit of 1 makes the pin an output, with pad_oe=1 and pad_out equal to the data bit when open-drain is 0. A direction bit of 0 keeps pad_oe at 0.
- R4: For an output pin whose open-drain bit is 1, the pin drives low (pad_oe=1, pad_out=0) when its data bit is 0, and it releases (pad_oe=0) when its data bit is 1. pad_out is never 1 while pad_oe is 1 on such a pin.
- R5: A read of the data register returns the last written data bit for output pins. For input pins it returns the pad level, which becomes visible two clock edges after the pad changes.
- R6: With edge-select bit 0, a rising or a falling pad edge sets the pin's event bit. With edge-select bit 1, only a falling edge sets it. The event bit is set at the third clock edge after the pad changes.
- R7: A write to the event register clears exactly the event bits that are 1 in the written word and leaves all other event bits unchanged.
- R8: irq is 1 exactly when the bitwise AND of the event and mask registers is nonzero.
- R9: If a new edge and a clearing write reach the same event bit at the same clock edge, the bit stays set.
- R10: Reset clears all registers to zero and leaves pad_oe and irq at 0. After software writes all ones to the event register and zero to the mask register, irq is 0 and the event register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Pad input levels, index = pin number |
| pad_out | output | 32 | Pad output levels, index = pin number |
| pad_oe | output | 32 | Pad output enables, index = pin number |
| irq | output | 1 | Combined masked event interrupt |

## Verification
The edge detector and the write-one-to-clear path can act on the same event bit at the same clock edge. The bench first latches an event on a pin. It then changes that pad and times the clearing write so that the write is captured at the third edge after the pad change, which is the edge where the new event lands. The event bit must read back as 1 after that edge. A clearing write with no edge present must then read back as 0, which shows that the clear path was really exercised.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   // register offsets (byte addresses)
   localparam int unsigned OFS_DIR = 'h00;
   localparam int unsigned OFS_OD  = 'h04;
   localparam int unsigned OFS_DAT = 'h08;
   localparam int unsigned OFS_EVT = 'h0C;
   localparam int unsigned OFS_MSK = 'h10;
   localparam int unsigned OFS_EDG = 'h14;

   typedef enum logic [2:0] {
      SEL_DIR,
      SEL_OD,
      SEL_DAT,
      SEL_EVT,
      SEL_MSK,
      SEL_EDG,
      SEL_NONE
   } reg_sel_e;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] cur_o,
   output logic [WIDTH-1:0] prev_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];
   logic [WIDTH-1:0] hist_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= stg_q[STAGES-1];
   end

   assign cur_o  = stg_q[STAGES-1];
   assign prev_o = hist_q;

endmodule

// File: rtl/gpio_edge_events.sv
module gpio_edge_events #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur_i,
   input  logic [WIDTH-1:0] prev_i,
   input  logic [WIDTH-1:0] fall_only_i,
   input  logic             clr_en_i,
   input  logic [WIDTH-1:0] clr_mask_i,
   output logic [WIDTH-1:0] evt_o
);

   logic [WIDTH-1:0] set_vec;
   logic [WIDTH-1:0] evt_q;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic any_edge;
         logic fall_edge;
         assign any_edge   = cur_i[b] ^ prev_i[b];
         assign fall_edge  = prev_i[b] & ~cur_i[b];
         assign set_vec[b] = fall_only_i[b] ? fall_edge : any_edge;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               evt_q[b] <= 1'b0;
            else if (set_vec[b])
               evt_q[b] <= 1'b1;          // a fresh edge beats a clear
            else if (clr_en_i && clr_mask_i[b])
               evt_q[b] <= 1'b0;
         end
      end
   endgenerate

   assign evt_o = evt_q;

   AST_EVT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en_i |=> ((evt_q & $past(clr_mask_i) & ~$past(set_vec)) == '0)); // R7

   AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_en_i |=> ((~evt_q & $past(evt_q)) == '0)); // R7

   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(set_vec) & ~evt_q) == '0)); // R9

   AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & ~$past(evt_q) & $past(fall_only_i) & ~$past(prev_i)) == '0)); // R6

endmodule

// File: rtl/gpio_edge_drive.sv
module gpio_edge_drive #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] dir_i,
   input  logic [WIDTH-1:0] od_i,
   input  logic [WIDTH-1:0] dat_i,
   output logic [WIDTH-1:0] out_o,
   output logic [WIDTH-1:0] oe_o
);

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_pin
         always_comb begin
            if (od_i[b]) begin
               out_o[b] = 1'b0;
               oe_o[b]  = dir_i[b] & ~dat_i[b];
            end else begin
               out_o[b] = dat_i[b];
               oe_o[b]  = dir_i[b];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr_en,
   input  logic [NUM_PINS-1:0] bus_wr_data,
   output logic [NUM_PINS-1:0] bus_rd_data,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq
);

   localparam int unsigned TOP_BIT = NUM_PINS - 1;

   generate
      if (NUM_PINS < 2) begin : g_bad_pins
         $error("gpio_edge_port: NUM_PINS must be at least 2");
      end
      if ((1 << ADDR_W) <= OFS_EDG) begin : g_bad_addr
         $error("gpio_edge_port: ADDR_W too narrow for the register map");
      end
   endgenerate

   // address decode
   reg_sel_e sel;
   always_comb begin
      case (bus_addr)
         ADDR_W'(OFS_DIR): sel = SEL_DIR;
         ADDR_W'(OFS_OD):  sel = SEL_OD;
         ADDR_W'(OFS_DAT): sel = SEL_DAT;
         ADDR_W'(OFS_EVT): sel = SEL_EVT;
         ADDR_W'(OFS_MSK): sel = SEL_MSK;
         ADDR_W'(OFS_EDG): sel = SEL_EDG;
         default:          sel = SEL_NONE;
      endcase
   end

   // control registers (register bit order)
   logic [NUM_PINS-1:0] dir_q, od_q, dat_q, msk_q, edg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         od_q  <= '0;
         dat_q <= '0;
         msk_q <= '0;
         edg_q <= '0;
      end else if (bus_wr_en) begin
         case (sel)
            SEL_DIR: dir_q <= bus_wr_data;
            SEL_OD:  od_q  <= bus_wr_data;
            SEL_DAT: dat_q <= bus_wr_data;
            SEL_MSK: msk_q <= bus_wr_data;
            SEL_EDG: edg_q <= bus_wr_data;
            default: ;
         endcase
      end
   end

   // pin order <-> register order: pin n sits at bit TOP_BIT-n
   logic [NUM_PINS-1:0] in_rb, out_rb, oe_rb, od_pins;
   generate
      for (genvar n = 0; n < NUM_PINS; n++) begin : g_flip
         assign in_rb[TOP_BIT-n] = pad_in[n];
         assign pad_out[n]       = out_rb[TOP_BIT-n];
         assign pad_oe[n]        = oe_rb[TOP_BIT-n];
         assign od_pins[n]       = od_q[TOP_BIT-n];
      end
   endgenerate

   logic [NUM_PINS-1:0] samp_cur, samp_prev, evt;

   gpio_edge_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (in_rb),
      .cur_o   (samp_cur),
      .prev_o  (samp_prev)
   );

   gpio_edge_events #(
      .WIDTH (NUM_PINS)
   ) u_events (
      .clk         (clk),
      .rst_n       (rst_n),
      .cur_i       (samp_cur),
      .prev_i      (samp_prev),
      .fall_only_i (edg_q),
      .clr_en_i    (bus_wr_en && (sel == SEL_EVT)),
      .clr_mask_i  (bus_wr_data),
      .evt_o       (evt)
   );

   gpio_edge_drive #(
      .WIDTH (NUM_PINS)
   ) u_drive (
      .dir_i (dir_q),
      .od_i  (od_q),
      .dat_i (dat_q),
      .out_o (out_rb),
      .oe_o  (oe_rb)
   );

   // read mux
   always_comb begin
      case (sel)
         SEL_DIR: bus_rd_data = dir_q;
         SEL_OD:  bus_rd_data = od_q;
         SEL_DAT: bus_rd_data = (dat_q & dir_q) | (samp_cur & ~dir_q);
         SEL_EVT: bus_rd_data = evt;
         SEL_MSK: bus_rd_data = msk_q;
         SEL_EDG: bus_rd_data = edg_q;
         default: bus_rd_data = '0;
      endcase
   end

   assign irq = |(evt & msk_q);

   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_q == '0) |-> !irq); // R8

   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_out & od_pins) == '0)); // R4

   AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q == '0) |-> (pad_oe == '0)); // R3

endmodule

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] A_DIR = 5'h00, A_OD = 5'h04, A_DAT = 5'h08,
                          A_EVT = 5'h0C, A_MSK = 5'h10, A_EDG = 5'h14, A_BAD = 5'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [31:0] bus_wr_data = '0;
   logic [31:0] bus_rd_data;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   gpio_edge_port u_dut (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr_en (bus_wr_en),
      .bus_wr_data (bus_wr_data), .bus_rd_data (bus_rd_data), .pad_in (pad_in),
      .pad_out (pad_out), .pad_oe (pad_oe), .irq (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] rb(int n);   // register bit of pin n
      return 32'h1 << (31 - n);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_read(logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rd_data;
   endtask

   task automatic set_pad(logic [31:0] v);
      @(negedge clk);
      pad_in = v;
   endtask

   task automatic settle_and_clear();
      repeat (3) @(negedge clk);
      bus_write(A_EVT, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      foreach (u_dut.bus_rd_data[i]) ;
      for (int a = 0; a < 6; a++) begin
         bus_read(5'(a * 4), d);
         check("R10 reset register", d, 32'h0);
      end
      check("R10 reset pad_oe", pad_oe, 32'h0);
      check("R10 reset irq", {31'h0, irq}, 32'h0);
      bus_write(A_EVT, 32'hFFFF_FFFF);
      bus_write(A_MSK, 32'h0);
      bus_read(A_EVT, d);
      check("R10 init event", d, 32'h0);
      check("R10 init irq", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      bus_write(A_DIR, 32'hA5A5_0001);
      bus_write(A_OD,  32'h0F0F_F0F0);
      bus_write(A_MSK, 32'h1234_5678);
      bus_write(A_EDG, 32'h8000_0003);
      bus_write(A_BAD, 32'hFFFF_FFFF);
      bus_read(A_DIR, d); check("R2 dir readback", d, 32'hA5A5_0001);
      bus_read(A_OD,  d); check("R2 od readback", d, 32'h0F0F_F0F0);
      bus_read(A_MSK, d); check("R2 mask readback", d, 32'h1234_5678);
      bus_read(A_EDG, d); check("R2 edge readback", d, 32'h8000_0003);
      bus_read(A_BAD, d); check("R2 unmapped read", d, 32'h0);
      bus_write(A_DIR, 0); bus_write(A_OD, 0); bus_write(A_MSK, 0); bus_write(A_EDG, 0);
   endtask

   task automatic t_drive();
      logic [31:0] d;
      bus_write(A_DIR, rb(3) | rb(0));
      bus_write(A_DAT, rb(3));
      check("R3/R1 push-pull oe", pad_oe, 32'h0000_0009);
      check("R3/R1 push-pull out", pad_out & pad_oe, 32'h0000_0008);
      bus_read(A_DAT, d);
      check("R5 data read outputs", d, rb(3));
      bus_write(A_OD, rb(3) | rb(0));
      check("R4 open-drain oe", pad_oe, 32'h0000_0001);
      check("R4 open-drain out", pad_out & pad_oe, 32'h0);
      bus_write(A_OD, 0); bus_write(A_DIR, 0); bus_write(A_DAT, 0);
   endtask

   task automatic t_data_mix();
      logic [31:0] d;
      bus_write(A_DIR, rb(1));
      bus_write(A_DAT, rb(1) | rb(2));
      set_pad(32'h0000_0014);              // pins 2 and 4 high
      @(negedge clk);
      bus_read(A_DAT, d);
      check("R5 pad not yet visible", d, rb(1));
      @(negedge clk);
      bus_read(A_DAT, d);
      check("R5/R1 mixed data read", d, rb(1) | rb(2) | rb(4));
      set_pad(32'h0);
      settle_and_clear();
      bus_write(A_DIR, 0); bus_write(A_DAT, 0);
   endtask

   task automatic t_both_edges();
      logic [31:0] d;
      set_pad(32'h1 << 5);
      repeat (2) @(negedge clk);
      bus_read(A_EVT, d); check("R6 rise latency edge 2", d, 32'h0);
      @(negedge clk);
      bus_read(A_EVT, d); check("R6 rise sets event", d, rb(5));
      bus_write(A_EVT, rb(5));
      bus_read(A_EVT, d); check("R7 cleared", d, 32'h0);
      set_pad(32'h0);
      repeat (3) @(negedge clk);
      bus_read(A_EVT, d); check("R6 fall sets event", d, rb(5));
      bus_write(A_EVT, 32'hFFFF_FFFF);
   endtask

   task automatic t_fall_only();
      logic [31:0] d;
      bus_write(A_EDG, rb(9));
      set_pad(32'h1 << 9);
      repeat (3) @(negedge clk);
      bus_read(A_EVT, d); check("R6 fall-only ignores rise", d, 32'h0);
      set_pad(32'h0);
      repeat (3) @(negedge clk);
      bus_read(A_EVT, d); check("R6 fall-only catches fall", d, rb(9));
      bus_write(A_EVT, 32'hFFFF_FFFF);
      bus_write(A_EDG, 0);
   endtask

   task automatic t_irq();
      set_pad(32'h1 << 12);
      repeat (3) @(negedge clk);
      check("R8 masked off", {31'h0, irq}, 32'h0);
      bus_write(A_MSK, rb(12));
      check("R8 mask enables irq", {31'h0, irq}, 32'h1);
      bus_write(A_MSK, rb(13));
      check("R8 other mask bit", {31'h0, irq}, 32'h0);
      bus_write(A_MSK, rb(12) | rb(13));
      bus_write(A_EVT, rb(12));
      check("R8/R7 clear drops irq", {31'h0, irq}, 32'h0);
      bus_write(A_MSK, 0);
      set_pad(32'h0);
      settle_and_clear();
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      set_pad((32'h1 << 20) | (32'h1 << 21));
      repeat (3) @(negedge clk);
      bus_read(A_EVT, d); check("R7 two events", d, rb(20) | rb(21));
      bus_write(A_EVT, rb(20));
      bus_read(A_EVT, d); check("R7 selective clear", d, rb(21));
      set_pad(32'h0);
      settle_and_clear();
   endtask

   task automatic t_race();
      logic [31:0] d;
      set_pad(32'h1 << 7);
      repeat (3) @(negedge clk);
      set_pad(32'h0);                      // new edge lands at 3rd edge
      @(negedge clk);
      bus_write(A_EVT, rb(7));             // captured on that same edge
      bus_read(A_EVT, d); check("R9 edge beats clear", d, rb(7));
      bus_write(A_EVT, rb(7));
      bus_read(A_EVT, d); check("R9 later clear works", d, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_drive();
      t_data_mix();
      t_both_edges();
      t_fall_only();
      t_irq();
      t_w1c();
      t_race();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule